// File: doc/BRIEF.md
# Staged-Update Phase-Accumulator PWM Channel

This block produces one pulse-width-modulated output. Its rate and duty come from a single 32-bit control register on a simple write-strobe and read-data bus. A phase accumulator of `BASE_W` bits advances by a programmable increment on every clock, so the output rate is the increment times the clock rate divided by 2^`BASE_W`. The output level comes from comparing the accumulator's upper eight bits against an 8-bit threshold. The threshold works inversely: a larger value gives a shorter high time.

Software writes the new increment and threshold into shadow storage and sets a request flag. The hardware moves both values into the active configuration together at the next output-cycle boundary and then clears the flag. Software polls the flag by reading the register, and it waits for the flag to clear before it issues another request. An output cycle begins on the first enabled clock and again every time the accumulator carries out of its top bit.

Top module: `pwm_stage_top`

## Requirements
- R1: After reset the register reads 0x0000_0000, the output is low and the active increment and threshold are zero.
- R2: Register layout: bit 31 is the enable and bit 30 is the update-request flag. The increment occupies bits 8+BASE_W-1 down to 8, and the threshold occupies bits 7:0. All other bits read zero. Reads return the enable, the flag and the shadow values. A write with bit 30 set sets the flag. A write with bit 30 clear leaves the flag unchanged.
- R3: While enabled, the accumulator adds the active increment on every clock, modulo 2^BASE_W. An output cycle ends on each carry, so the output period is 2^BASE_W / increment clocks.
- R4: While enabled, the output is high when the accumulator's top eight bits are greater than or equal to the active threshold, and low otherwise. A threshold of 0 keeps the output high.
- R5: Writes change only the shadow values. The active values change only at a cycle boundary while the flag is set, and a later write made before that boundary replaces an earlier pending one.
- R6: At a cycle boundary with the flag set, the shadow values move to the active ones and the flag clears on the same clock. The first clock after enabling is a boundary.
- R7: While disabled, the output is low and the accumulator stays at zero. A pending flag stays set.
- R8: An active increment of zero freezes the accumulator and the output. No boundary then occurs after the start of the cycle, and a pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest state to reach from the ports is a pending request that can never complete, because the active increment is zero and no boundary comes. The stimulus loads a zero increment through a normal request and waits for that request to take effect. It then posts two further requests and shows that both the flag and the frozen output stay put. A disable and re-enable then forces a start boundary, and the bench checks that the last of the stacked requests is the one that takes effect. Duty is measured as the number of high samples in a 16-clock window, and rate as the number of rising edges in a 32-clock window.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;
  localparam int EN_BIT   = 31;
  localparam int UPD_BIT  = 30;
  localparam int BASE_LSB = 8;
  localparam int THR_W    = 8;
  localparam int REG_W    = 32;
endpackage

// File: rtl/pwm_stage_regs.sv
module pwm_stage_regs
  import pwm_stage_pkg::*;
#(
  parameter int BASE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              boundary_i,
  output logic              en_o,
  output logic              upd_o,
  output logic [BASE_W-1:0] shd_base_o,
  output logic [THR_W-1:0]  shd_thr_o,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam int BASE_MSB = BASE_LSB + BASE_W - 1;

  if (BASE_W < THR_W || BASE_MSB >= UPD_BIT) begin : g_bad_width
    $error("BASE_W out of range");
  end

  logic wr_set;
  assign wr_set = wr_en_i && wr_data_i[UPD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      upd_o      <= 1'b0;
      shd_base_o <= '0;
      shd_thr_o  <= '0;
    end else begin
      if (wr_en_i) begin
        en_o       <= wr_data_i[EN_BIT];
        shd_base_o <= wr_data_i[BASE_MSB:BASE_LSB];
        shd_thr_o  <= wr_data_i[THR_W-1:0];
      end
      // a new request wins over a clear on the same clock
      if (wr_set)          upd_o <= 1'b1;
      else if (boundary_i) upd_o <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[EN_BIT]            = en_o;
    rd_data_o[UPD_BIT]           = upd_o;
    rd_data_o[BASE_MSB:BASE_LSB] = shd_base_o;
    rd_data_o[THR_W-1:0]         = shd_thr_o;
  end
endmodule

// File: rtl/pwm_stage_active.sv
module pwm_stage_active
  import pwm_stage_pkg::*;
#(
  parameter int BASE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              upd_i,
  input  logic [BASE_W-1:0] shd_base_i,
  input  logic [THR_W-1:0]  shd_thr_i,
  output logic [BASE_W-1:0] act_base_o,
  output logic [THR_W-1:0]  act_thr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_base_o <= '0;
      act_thr_o  <= '0;
    end else if (boundary_i && upd_i) begin
      act_base_o <= shd_base_i;
      act_thr_o  <= shd_thr_i;
    end
  end
endmodule

// File: rtl/pwm_stage_phase.sv
module pwm_stage_phase
  import pwm_stage_pkg::*;
#(
  parameter int BASE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BASE_W-1:0] inc_i,
  output logic              boundary_o,
  output logic [BASE_W-1:0] acc_o,
  output logic [THR_W-1:0]  top_o
);
  logic          run_q;
  logic [BASE_W:0] sum;

  assign sum        = {1'b0, acc_o} + {1'b0, inc_i};
  // cycle starts on first enabled clock, then on every carry
  assign boundary_o = en_i && (!run_q || sum[BASE_W]);
  assign top_o      = acc_o[BASE_W-1 -: THR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      acc_o <= '0;
    end else begin
      run_q <= en_i;
      if (!en_i || !run_q) acc_o <= '0;
      else                 acc_o <= sum[BASE_W-1:0];
    end
  end
endmodule

// File: rtl/pwm_stage_cmp.sv
module pwm_stage_cmp
  import pwm_stage_pkg::*;
(
  input  logic             en_i,
  input  logic [THR_W-1:0] top_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             pwm_o
);
  assign pwm_o = en_i && (top_i >= thr_i);
endmodule

// File: rtl/pwm_stage_top.sv
module pwm_stage_top
  import pwm_stage_pkg::*;
#(
  parameter int BASE_W = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        pwm_o
);
  logic              en_q;
  logic              upd_q;
  logic              boundary;
  logic [BASE_W-1:0] shd_base;
  logic [THR_W-1:0]  shd_thr;
  logic [BASE_W-1:0] act_base;
  logic [THR_W-1:0]  act_thr;
  logic [BASE_W-1:0] acc_q;
  logic [THR_W-1:0]  acc_top;

  pwm_stage_regs #(.BASE_W(BASE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .boundary_i (boundary),
    .en_o       (en_q),
    .upd_o      (upd_q),
    .shd_base_o (shd_base),
    .shd_thr_o  (shd_thr),
    .rd_data_o  (rd_data_o)
  );

  pwm_stage_active #(.BASE_W(BASE_W)) u_active (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary),
    .upd_i      (upd_q),
    .shd_base_i (shd_base),
    .shd_thr_i  (shd_thr),
    .act_base_o (act_base),
    .act_thr_o  (act_thr)
  );

  pwm_stage_phase #(.BASE_W(BASE_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .inc_i      (act_base),
    .boundary_o (boundary),
    .acc_o      (acc_q),
    .top_o      (acc_top)
  );

  pwm_stage_cmp u_cmp (
    .en_i  (en_q),
    .top_i (acc_top),
    .thr_i (act_thr),
    .pwm_o (pwm_o)
  );
endmodule

// File: rtl/pwm_stage_chk.sv
module pwm_stage_chk #(
  parameter int BASE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [31:0]       wr_data_i,
  input logic [31:0]       rd_data_o,
  input logic              pwm_o,
  input logic              en_q,
  input logic              upd_q,
  input logic              boundary,
  input logic [BASE_W-1:0] acc_q,
  input logic [BASE_W-1:0] act_base,
  input logic [7:0]        act_thr,
  input logic [7:0]        shd_thr
);
  // R7
  disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[31] |-> !pwm_o);

  // R7
  disabled_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> acc_q == '0);

  // R6
  upd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q && boundary && !(wr_en_i && wr_data_i[30]) |=> !upd_q);

  // R5
  upd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q && !boundary |=> upd_q);

  // R5
  act_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(boundary && upd_q) |=> $stable(act_thr) && $stable(act_base));

  // R6
  act_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary && upd_q |=> act_thr == $past(shd_thr));

  // R2
  wr_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[7:0] == $past(wr_data_i[7:0]));

  // R8
  base_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && $past(en_q) && act_base == '0 |-> !boundary);

  // R4
  thr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && act_thr == 8'd0 |-> pwm_o);
endmodule

bind pwm_stage_top pwm_stage_chk #(.BASE_W(BASE_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .pwm_o     (pwm_o),
  .en_q      (en_q),
  .upd_q     (upd_q),
  .boundary  (boundary),
  .acc_q     (acc_q),
  .act_base  (act_base),
  .act_thr   (act_thr),
  .shd_thr   (shd_thr)
);

// File: tb/pwm_stage_top_tb_top.sv
module pwm_stage_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  typedef enum int {K_RD, K_PWM, K_HIGH, K_RISE} kind_e;
  typedef struct {
    string       req;
    kind_e       kind;
    logic [31:0] exp;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        pwm_o;

  item_t sb_q[$];
  int    checks = 0;
  int    failures = 0;
  int    hi_cnt = 0;
  int    rise_cnt = 0;
  bit    cnt_en = 1'b0;
  logic  prev_pwm = 1'b0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_stage_top #(.BASE_W(10)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .pwm_o     (pwm_o)
  );

  // monitor: counts during windows, pops and compares scoreboard items
  always @(negedge clk_i) begin
    logic [31:0] act;
    if (cnt_en) begin
      hi_cnt   += int'(pwm_o);
      rise_cnt += int'(pwm_o && !prev_pwm);
    end
    prev_pwm = pwm_o;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    act = rd_data_o;
        K_PWM:   act = {31'd0, pwm_o};
        K_HIGH:  act = hi_cnt;
        default: act = rise_cnt;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=0x%08h expected=0x%08h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input string req, input kind_e k, input logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = k; it.exp = exp;
    sb_q.push_back(it);
    @(negedge clk_i); #1;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic window(input int n);
    @(posedge clk_i); #1;
    hi_cnt = 0; rise_cnt = 0; cnt_en = 1'b1;
    repeat (n) @(negedge clk_i);
    #1 cnt_en = 1'b0;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    push("R1", K_RD, 32'h0000_0000);
    push("R1", K_PWM, 32'd0);

    // R2 unused bits 29:18 read zero; increment 64, threshold 128
    wr(32'hC3FC_4080);
    push("R2", K_RD, 32'hC000_4080);
    step(1);
    push("R6", K_RD, 32'h8000_4080);   // start boundary cleared flag
    step(20);
    window(16);
    push("R4", K_HIGH, 32'd8);
    window(32);
    push("R3", K_RISE, 32'd2);

    // R5 no request: shadow changes, output does not
    wr(32'h8000_40C0);
    push("R2", K_RD, 32'h8000_40C0);
    step(20);
    window(16);
    push("R5", K_HIGH, 32'd8);

    // request applies at next carry
    wr(32'hC000_40C0);
    push("R2", K_RD, 32'hC000_40C0);
    step(40);
    push("R6", K_RD, 32'h8000_40C0);
    window(16);
    push("R4", K_HIGH, 32'd4);

    // R3 rate doubles with increment 128, threshold 64
    wr(32'hC000_8040);
    step(40);
    window(32);
    push("R3", K_RISE, 32'd4);
    window(16);
    push("R4", K_HIGH, 32'd12);

    // R8 zero increment freezes accumulator at 0
    wr(32'hC000_0040);
    step(40);
    push("R8", K_RD, 32'h8000_0040);
    window(16);
    push("R8", K_HIGH, 32'd0);

    wr(32'hC000_4000);
    step(40);
    push("R8", K_RD, 32'hC000_4000);   // flag never clears
    window(16);
    push("R8", K_HIGH, 32'd0);
    wr(32'hC000_40C0);
    push("R5", K_RD, 32'hC000_40C0);   // pending shadow overwritten
    wr(32'h8000_40C0);
    push("R2", K_RD, 32'hC000_40C0);   // bit30 clear leaves flag

    // R7 disable: low, flag stays
    wr(32'h0000_40C0);
    push("R7", K_PWM, 32'd0);
    step(20);
    push("R7", K_RD, 32'h4000_40C0);
    window(16);
    push("R7", K_HIGH, 32'd0);

    // re-enable: start boundary applies last pending request
    wr(32'h8000_40C0);
    push("R6", K_RD, 32'hC000_40C0);
    step(1);
    push("R6", K_RD, 32'h8000_40C0);
    step(20);
    window(16);
    push("R5", K_HIGH, 32'd4);

    // R4 threshold 0 keeps output high
    wr(32'hC000_4000);
    step(40);
    window(16);
    push("R4", K_HIGH, 32'd16);

    done = 1'b1;
    step(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule